// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the read-side control of a 16-bit memory that can be read in two ways. A 16-bit configuration word selects the way. In asynchronous page mode the block returns, in the same cycle, the word at the presented address while the chip select is high. In synchronous burst mode the block samples a start address on an address-valid strobe. It then counts a programmed latency and streams words from a computed internal word model. Each word is held for one or two clocks. A burst is 4, 8, 16 or an unbounded number of words, and a fixed-length burst either wraps inside its aligned window or runs on linearly. A WAIT output tells the host when data is not yet valid. Its active level is programmable, and it can drop either together with the first word or one data cycle earlier.

The sequencer is a three-state machine. ST_IDLE moves to ST_LAT on a qualified strobe (transition "start"). ST_LAT counts the latency down and moves to ST_DATA when the count reaches zero ("lat_done"). ST_DATA returns to ST_IDLE after the last word of a fixed burst ("burst_done"). A new strobe in any state restarts the burst ("restart"). A low chip select in any state forces ST_IDLE ("deselect").

The internal word model returns, for an 8-bit address a, the word {a XOR 8'h5A, ~a}.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset, cfg_q reads 16'h9FCF (page mode, latency code 3, WAIT active-high, two-clock hold, early WAIT, linear order, rising edge, no wrap, continuous), cfg_err is 0, data_vld is 0 and wait_o is 0.
- R2: When cfg_q bit 15 is 1, data_vld equals csel in the same cycle and rdata is the model word of addr while csel is high. The address-valid strobe has no effect in this mode.
- R3: A configuration write is rejected when any of the following holds: bit 14, 5 or 4 is nonzero; bit 7 is 0; bits 2:0 are not 001, 010, 011 or 111; the latency code in bits 13:11 is outside 1..4; or the latency code is 2 with bit 9 and bit 8 both 1. A rejected write keeps cfg_q and sets cfg_err. An accepted write loads cfg_q and clears cfg_err.
- R4: In burst mode (bit 15 = 0), suppose the strobe is sampled high with csel at clock edge k, and the latency code is L. Then data_vld first rises right after edge k+L, and the first word is the model word of the sampled address.
- R5: With bit 9 = 0 each word is presented for one clock. With bit 9 = 1 each word is presented for two clocks.
- R6: The logical WAIT is asserted during the latency cycles and deasserted everywhere else. With bit 8 = 0 it drops when data_vld rises. With bit 8 = 1 it drops one data cycle earlier, which is 1 clock when bit 9 = 0 and 2 clocks when bit 9 = 1.
- R7: wait_o equals the logical WAIT when bit 10 is 1 and its inverse when bit 10 is 0.
- R8: Bits 2:0 equal to 001, 010 or 011 give bursts of 4, 8 or 16 words, after which data_vld falls. Word i of a burst from base b reads address b+i when bit 3 = 1. When bit 3 = 0 it reads (b AND NOT(N-1)) OR ((b+i) AND (N-1)).
- R9: Bits 2:0 = 111 stream words at consecutive addresses, modulo the address width, with no end and no wrap window, regardless of bit 3.
- R10: Bit 6 is stored and read back. A value of 0 does not change the timing of any output.
- R11: If csel is sampled low at a clock edge, the burst ends and data_vld is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_q | output | 16 | Current configuration |
| cfg_err | output | 1 | Last configuration write was rejected |
| csel | input | 1 | Chip select, active high |
| adv | input | 1 | Address-valid strobe, active high |
| addr | input | ADDR_W | Read address |
| rdata | output | 16 | Read data |
| data_vld | output | 1 | Read data is valid |
| wait_o | output | 1 | WAIT, polarity set by configuration |

## Verification
The embedded assertions check on every cycle that:
- the stored configuration is always a legal one;
- the latency counter stays within range;
- the address holds still during the first clock of a two-clock word;
- WAIT is inactive whenever burst data is valid;
- a wrapping fixed burst stays inside its aligned window;
- a deselect ends the burst.

Only the bench scenarios can show the exact cycle of the first word for each latency code and the early-versus-aligned WAIT drop. They also show the address order under wrap, no-wrap and continuous streaming, the rejection of each class of illegal configuration, and that a falling-edge setting leaves the timing unchanged.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int CFG_W  = 16;
    localparam int WORD_W = 16;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h9FCF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    localparam logic [2:0] LEN_CONT = 3'b111;

    function automatic logic [WORD_W-1:0] word_model(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             err
);

    function automatic logic is_legal(input logic [CFG_W-1:0] v);
        logic [2:0] lc;
        logic       len_ok;
        lc     = v[13:11];
        len_ok = (v[2:0] == 3'b001) || (v[2:0] == 3'b010) ||
                 (v[2:0] == 3'b011) || (v[2:0] == LEN_CONT);
        return !v[14] && (v[5:4] == 2'b00) && v[7] && len_ok &&
               (lc != 3'd0) && (lc <= 3'd4) &&
               !((lc == 3'd2) && v[9] && v[8]);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
            err   <= 1'b0;
        end else if (we) begin
            if (is_legal(wdata)) begin
                cfg_q <= wdata;
                err   <= 1'b0;
            end else begin
                err   <= 1'b1;
            end
        end
    end

    // R3
    cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[14] && cfg_q[5:4] == 2'b00 && cfg_q[7] &&
         cfg_q[13:11] != 3'd0 && cfg_q[13:11] <= 3'd4));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [2:0]        len_code,
    input  logic              wrap_en,
    output logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] win_mask
);

    logic [ADDR_W-1:0] inc;

    always_comb begin
        unique case (len_code)
            3'b001:  win_mask = ADDR_W'(3);
            3'b010:  win_mask = ADDR_W'(7);
            3'b011:  win_mask = ADDR_W'(15);
            default: win_mask = '1;
        endcase
        inc = cur + ADDR_W'(1);
        if (wrap_en && len_code != 3'b111)
            nxt = (cur & ~win_mask) | (inc & win_mask);
        else
            nxt = inc;
    end

endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csel,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              burst_en,
    input  logic [2:0]        lat_code,
    input  logic              hold2,
    input  logic              early_wt,
    input  logic [2:0]        len_code,
    input  logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] base_addr,
    output logic              in_data,
    output logic              wait_act
);

    seq_state_e state, nxt_state;
    logic [2:0] lat_cnt;
    logic [3:0] beats;
    logic       phase;
    logic       start, adv_word, last, fixed;
    logic [3:0] len_m1;

    always_comb begin
        unique case (len_code)
            3'b001:  len_m1 = 4'd3;
            3'b010:  len_m1 = 4'd7;
            3'b011:  len_m1 = 4'd15;
            default: len_m1 = 4'd0;
        endcase
        fixed    = (len_code != LEN_CONT);
        start    = csel && adv && burst_en;
        adv_word = (state == ST_DATA) && (!hold2 || phase);
        last     = fixed && (beats == len_m1);
    end

    always_comb begin
        unique case (state)
            ST_IDLE: nxt_state = ST_IDLE;
            ST_LAT:  nxt_state = (lat_cnt == 3'd0) ? ST_DATA : ST_LAT;
            ST_DATA: nxt_state = (adv_word && last) ? ST_IDLE : ST_DATA;
            default: nxt_state = ST_IDLE;
        endcase
        if (start) nxt_state = ST_LAT;
        if (!csel) nxt_state = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            base_addr <= '0;
            lat_cnt   <= 3'd0;
            beats     <= 4'd0;
            phase     <= 1'b0;
        end else if (start) begin
            cur_addr  <= addr_in;
            base_addr <= addr_in;
            lat_cnt   <= 3'(lat_code - 3'd1);
            beats     <= 4'd0;
            phase     <= 1'b0;
        end else if (state == ST_LAT) begin
            if (lat_cnt != 3'd0) lat_cnt <= lat_cnt - 3'd1;
        end else if (state == ST_DATA) begin
            if (hold2 && !phase) begin
                phase <= 1'b1;
            end else begin
                phase    <= 1'b0;
                cur_addr <= nxt_addr;
                beats    <= beats + 4'd1;
            end
        end
    end

    always_comb begin
        in_data  = (state == ST_DATA);
        wait_act = (state == ST_LAT) &&
                   !(early_wt && (lat_cnt < (hold2 ? 3'd2 : 3'd1)));
    end

    // R4
    lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LAT) |-> (lat_cnt < 3'd4));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && hold2 && !phase && csel && !start) |=> $stable(cur_addr));

    // R11
    desel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csel |=> (state == ST_IDLE));

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_q,
    output logic              cfg_err,
    input  logic              csel,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    output logic [15:0]       rdata,
    output logic              data_vld,
    output logic              wait_o
);

    logic [ADDR_W-1:0] cur_addr, base_addr, nxt_addr, win_mask;
    logic              in_data, wait_act, page_mode;
    logic              unused_cfg;

    burst_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q),
        .err   (cfg_err)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .cur      (cur_addr),
        .len_code (cfg_q[2:0]),
        .wrap_en  (!cfg_q[3]),
        .nxt      (nxt_addr),
        .win_mask (win_mask)
    );

    burst_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .csel      (csel),
        .adv       (adv),
        .addr_in   (addr),
        .burst_en  (!cfg_q[15]),
        .lat_code  (cfg_q[13:11]),
        .hold2     (cfg_q[9]),
        .early_wt  (cfg_q[8]),
        .len_code  (cfg_q[2:0]),
        .nxt_addr  (nxt_addr),
        .cur_addr  (cur_addr),
        .base_addr (base_addr),
        .in_data   (in_data),
        .wait_act  (wait_act)
    );

    assign page_mode  = cfg_q[15];
    assign unused_cfg = ^{cfg_q[14], cfg_q[7:4]};

    always_comb begin
        if (page_mode) begin
            data_vld = csel;
            rdata    = csel ? word_model(addr[7:0]) : '0;
        end else begin
            data_vld = in_data;
            rdata    = in_data ? word_model(cur_addr[7:0]) : '0;
        end
        wait_o = wait_act ^ ~cfg_q[10];
    end

    // R7
    wait_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_mode && data_vld) |-> (wait_o == ~cfg_q[10]));

    // R8
    wrap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !cfg_q[3] && cfg_q[2:0] != LEN_CONT) |->
        ((cur_addr & ~win_mask) == (base_addr & ~win_mask)));

endmodule

// File: tb/burst_rd_seq_tb_top.sv
module burst_rd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic        cfg_err;
    logic        csel = 1'b0;
    logic        adv = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] rdata;
    logic        data_vld;
    logic        wait_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    burst_rd_seq #(.ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .cfg_err   (cfg_err),
        .csel      (csel),
        .adv       (adv),
        .addr      (addr),
        .rdata     (rdata),
        .data_vld  (data_vld),
        .wait_o    (wait_o)
    );

    function automatic logic [15:0] tb_word(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    function automatic logic [15:0] mk_cfg(input logic pg, input logic [2:0] lc,
                                           input logic wp, input logic dh, input logic wd,
                                           input logic ce, input logic bw, input logic [2:0] bl);
        return {pg, 1'b0, lc, wp, dh, wd, 1'b1, ce, 2'b00, bw, bl};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: one expected item per cycle while the queue holds items
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [17:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (data_vld !== e[17] || wait_o !== e[16] ||
                (e[17] && rdata !== e[15:0])) begin
                n_fail++;
                $display("FAIL %s actual vld=%b wait=%b data=%h expected vld=%b wait=%b data=%h",
                         t, data_vld, wait_o, rdata, e[17], e[16], e[15:0]);
            end
        end
    end

    task automatic cfg_write(input logic [15:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input logic v, input logic w, input logic [15:0] d, input string t);
        exp_q.push_back({v, w, d});
        tag_q.push_back(t);
    endtask

    task automatic run_burst(input logic [7:0] base, input int lc, input logic dh,
                             input logic wd, input logic wp, input logic [2:0] bl,
                             input logic bw, input int cont_words, input string tag);
        int          dcyc, nw;
        logic        fixed;
        logic [7:0]  mask, a;
        dcyc  = dh ? 2 : 1;
        fixed = (bl != 3'b111);
        case (bl)
            3'b001:  begin nw = 4;  mask = 8'd3;  end
            3'b010:  begin nw = 8;  mask = 8'd7;  end
            3'b011:  begin nw = 16; mask = 8'd15; end
            default: begin nw = cont_words; mask = 8'hFF; end
        endcase
        @(posedge clk); #1;
        csel = 1'b1; adv = 1'b1; addr = base;
        @(posedge clk); #1;
        adv = 1'b0;
        for (int c = 0; c < lc; c++) begin
            int  cnt;
            logic wt;
            cnt = lc - 1 - c;
            wt  = !(wd && cnt < dcyc);
            push(1'b0, wt ? wp : ~wp, 16'h0, "R6");
        end
        for (int i = 0; i < nw; i++) begin
            if (fixed && !bw) a = (base & ~mask) | ((base + 8'(i)) & mask);
            else              a = base + 8'(i);
            for (int h = 0; h < dcyc; h++)
                push(1'b1, ~wp, tb_word(a), (i == 0 && h == 0) ? "R4" : tag);
        end
        if (!fixed) begin
            repeat (lc + nw * dcyc - 1) @(posedge clk);
            #1 csel = 1'b0;
            push(1'b0, ~wp, 16'h0, "R11");
        end else begin
            push(1'b0, ~wp, 16'h0, "R8");
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
        csel = 1'b0;
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] keep;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg_q", 32'(cfg_q), 32'h9FCF);
        check("R1 cfg_err", 32'(cfg_err), 32'h0);
        check("R1 data_vld", 32'(data_vld), 32'h0);
        check("R1 wait_o", 32'(wait_o), 32'h0);

        // R2 page mode
        @(posedge clk); #1;
        csel = 1'b1; addr = 8'h21;
        @(negedge clk);
        check("R2 vld", 32'(data_vld), 32'h1);
        check("R2 data", 32'(rdata), 32'(tb_word(8'h21)));
        #1 addr = 8'hC4; adv = 1'b1;
        @(posedge clk); #1 adv = 1'b0;
        @(negedge clk);
        check("R2 data strobe ignored", 32'(rdata), 32'(tb_word(8'hC4)));
        check("R2 wait strobe ignored", 32'(wait_o), 32'h0);
        #1 csel = 1'b0;
        @(negedge clk);
        check("R2 vld deselect", 32'(data_vld), 32'h0);

        // R3 rejected writes
        keep = cfg_q;
        cfg_write(mk_cfg(1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b100));
        check("R3 bad length keeps", 32'(cfg_q), 32'(keep));
        check("R3 bad length err", 32'(cfg_err), 32'h1);
        cfg_write(mk_cfg(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001));
        check("R3 latency 0 keeps", 32'(cfg_q), 32'(keep));
        cfg_write(mk_cfg(1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001));
        check("R3 latency 5 keeps", 32'(cfg_q), 32'(keep));
        cfg_write(mk_cfg(1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'b001));
        check("R3 lc2 hold2 early keeps", 32'(cfg_q), 32'(keep));
        cfg_write(16'h1F4F);
        check("R3 order bit keeps", 32'(cfg_q), 32'(keep));
        cfg_write(16'h1FDF);
        check("R3 reserved bits keeps", 32'(cfg_q), 32'(keep));
        check("R3 err still set", 32'(cfg_err), 32'h1);

        // R8 wrap 4-word, one-clock hold, aligned WAIT
        cfg_write(mk_cfg(1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001));
        check("R3 legal write loads", 32'(cfg_q),
              32'(mk_cfg(1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001)));
        check("R3 legal write clears err", 32'(cfg_err), 32'h0);
        run_burst(8'h06, 3, 1'b0, 1'b0, 1'b1, 3'b001, 1'b0, 0, "R8");

        // R5 two-clock hold, 8-word no-wrap, early WAIT, latency 4
        cfg_write(mk_cfg(1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'b010));
        run_burst(8'h3D, 4, 1'b1, 1'b1, 1'b1, 3'b010, 1'b1, 0, "R5");

        // R7 active-low WAIT, 16-word wrap, latency 2, two-clock hold
        cfg_write(mk_cfg(1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b011));
        run_burst(8'hF5, 2, 1'b1, 1'b0, 1'b0, 3'b011, 1'b0, 0, "R7");

        // R9 continuous with wrap bit set, latency 1, ended by deselect (R11)
        cfg_write(mk_cfg(1'b0, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b111));
        run_burst(8'hFE, 1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b0, 6, "R9");

        // R10 falling-edge setting stored, timing unchanged
        cfg_write(mk_cfg(1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001));
        check("R10 edge bit stored", 32'(cfg_q[6]), 32'h0);
        run_burst(8'h10, 2, 1'b0, 1'b1, 1'b1, 3'b001, 1'b1, 0, "R10");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule